// File: doc/BRIEF.md
# Repeat-Mode DMA Channel

This block is one DMA channel that copies words, one at a time, from a source address to a destination address. Each word is one read followed by one write on a simple request/acknowledge memory port. A down-counter tracks the words that remain. The source and destination addresses can each stay fixed or advance by one word (4 bytes) after every transfer.

Two status flags tell software where the channel is in its buffer. The half flag is set when the remaining count falls to half of the backup count. The end flag is set when the count reaches zero. In repeat mode, terminal count does not stop the channel. The destination address and the count are reloaded from their backup registers, and transfers continue. Software can then work on one half of a destination ring while the channel fills the other half.

The channel runs while its own enable and the global DMA enable input are both high. A non-maskable interrupt input clears the channel enable.

Top module: `rdma_chan`

## Requirements
- R1: After reset, every register (CTRL, STAT, SRC, DST, CNT, DSTB, CNTB) reads zero, `irq` is low and `mem_req` is low.
- R2: Each transfer reads the word at SRC and then writes that word to DST. CNT drops by one per word. While `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` hold their values.
- R3: The source mode CTRL[4:3] and the destination mode CTRL[6:5] each work as follows: 01 adds 4 to the address after every transfer, and any other value, including 00, keeps the address fixed.
- R4: When CTRL[2] (half enable) is 1 and CNT after a decrement equals CNTB shifted right by one, STAT[0] is set. When CTRL[2] is 0, STAT[0] is never set.
- R5: When CNT reaches zero, STAT[1] is set. If CTRL[9:7] is not 010, no further memory request is issued.
- R6: If CTRL[9:7] is 010 when CNT reaches zero, DST is loaded from DSTB and CNT from CNTB in the same cycle, and transfers continue.
- R7: `irq` equals CTRL[1] AND ((STAT[0] AND CTRL[2]) OR STAT[1]).
- R8: Writing 0 to a STAT bit clears that flag, and writing 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R9: A new transfer starts only while CTRL[0] and `dma_en` are both 1. Once either drops, the word in flight completes and no further request follows.
- R10: A high `nmi` in any cycle clears CTRL[0] on the next clock edge.
- R11: Writes to SRC, DST or CNT are ignored while the channel is enabled or a word is in flight. A write to DSTB or CNTB while running takes effect at the next reload.

Register offsets on `reg_addr`: 0 CTRL, 1 STAT, 2 SRC, 3 DST, 4 CNT, 5 DSTB, 6 CNTB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Global DMA enable |
| nmi | input | 1 | Non-maskable interrupt; stops the channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current request |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong count or a wrong reload shows up at the memory port as a write address outside the expected ring. This appears on the first write after terminal count, so the bench logs every write address across two repeat cycles. A flag that is set at the wrong point is visible on STAT and `irq` in the half-cycle after the write acknowledge that should have caused it, so the flags are sampled exactly there. A run condition that fails to stop the channel shows up as extra requests within a few cycles, which the bench counts over a quiet window.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_SRC  = 3'd2;
  localparam logic [2:0] REG_DST  = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_DSTB = 3'd5;
  localparam logic [2:0] REG_CNTB = 3'd6;

  localparam logic [1:0] AM_FIXED = 2'b00;
  localparam logic [1:0] AM_INC   = 2'b01;

  localparam logic [2:0] RPT_DST  = 3'b010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;

  typedef struct packed {
    logic [2:0] rpt;
    logic [1:0] dmode;
    logic [1:0] smode;
    logic       he_en;
    logic       ie;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rdma_addr_step.sv
module rdma_addr_step
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_B = 4
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] nxt
);

  always_comb begin
    if (mode == AM_INC) nxt = addr + ADDR_W'(STEP_B);
    else                nxt = addr;
  end

endmodule

// File: rtl/rdma_ctrl_regs.sv
module rdma_ctrl_regs
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_dstb,
  input  logic              wr_cntb,
  input  ctrl_t             ctrl_wdata,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              nmi,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] dstb_q,
  output logic [CNT_W-1:0]  cntb_q
);

  ctrl_t ctrl_d;
  logic  ctrl_ce;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_ce = wr_ctrl | nmi;
    if (wr_ctrl) ctrl_d = ctrl_wdata;
    if (nmi)     ctrl_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dstb_q <= '0;
      cntb_q <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (wr_dstb) dstb_q <= addr_wdata;
      if (wr_cntb) cntb_q <= cnt_wdata;
    end
  end

  // R10
  nmi_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !ctrl_q.en);

endmodule

// File: rtl/rdma_xfer.sv
module rdma_xfer
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP_B = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        smode,
  input  logic [1:0]        dmode,
  input  logic              rpt_dst,
  input  logic [ADDR_W-1:0] dstb,
  input  logic [CNT_W-1:0]  cntb,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              half_evt,
  output logic              tc_evt
);

  xfer_st_e          st_q, st_d;
  logic [DATA_W-1:0] buf_q;
  logic [ADDR_W-1:0] src_d, dst_d, src_step, dst_step;
  logic [CNT_W-1:0]  cnt_d, cnt_dec;
  logic              src_ce, dst_ce, cnt_ce, buf_ce;
  logic              quiet, rd_done, wr_done, at_tc;

  rdma_addr_step #(.ADDR_W(ADDR_W), .STEP_B(STEP_B)) u_src_step (
    .mode(smode), .addr(src_q), .nxt(src_step)
  );

  rdma_addr_step #(.ADDR_W(ADDR_W), .STEP_B(STEP_B)) u_dst_step (
    .mode(dmode), .addr(dst_q), .nxt(dst_step)
  );

  assign quiet   = (st_q == ST_IDLE) && !run;
  assign rd_done = (st_q == ST_RD) && mem_ack;
  assign wr_done = (st_q == ST_WR) && mem_ack;
  assign cnt_dec = cnt_q - CNT_W'(1);
  assign at_tc   = (cnt_dec == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (run && (cnt_q != '0)) st_d = ST_RD;
      ST_RD:   if (mem_ack) st_d = ST_WR;
      ST_WR:   if (mem_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    buf_ce = rd_done;
    src_ce = wr_done | (quiet & wr_src);
    dst_ce = wr_done | (quiet & wr_dst);
    cnt_ce = wr_done | (quiet & wr_cnt);
    src_d  = wr_done ? src_step : addr_wdata;
    if (wr_done) begin
      dst_d = (at_tc && rpt_dst) ? dstb : dst_step;
      cnt_d = (at_tc && rpt_dst) ? cntb : cnt_dec;
    end else begin
      dst_d = addr_wdata;
      cnt_d = cnt_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      buf_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (buf_ce) buf_q <= mem_rdata;
      if (src_ce) src_q <= src_d;
      if (dst_ce) dst_q <= dst_d;
      if (cnt_ce) cnt_q <= cnt_d;
    end
  end

  assign half_evt  = wr_done && (cnt_dec == (cntb >> 1));
  assign tc_evt    = wr_done && at_tc;
  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = buf_q;

  // R2
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && (cnt_q == CNT_W'(1)) && rpt_dst)
      |=> ((cnt_q == $past(cntb)) && (dst_q == $past(dstb))));

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !run) |=> !mem_req);

  // R3
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && (smode == AM_FIXED)) |=> $stable(src_q));

endmodule

// File: rtl/rdma_status.sv
module rdma_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_evt,
  input  logic       tc_evt,
  input  logic       he_en,
  input  logic       ie,
  input  logic       wr_stat,
  input  logic [1:0] stat_wdata,
  output logic       he_q,
  output logic       te_q,
  output logic       irq
);

  logic he_set, he_clr, he_ce, he_d;
  logic te_set, te_clr, te_ce, te_d;

  always_comb begin
    he_set = half_evt & he_en;
    he_clr = wr_stat & ~stat_wdata[0];
    he_ce  = he_set | he_clr;
    he_d   = he_set;
    te_set = tc_evt;
    te_clr = wr_stat & ~stat_wdata[1];
    te_ce  = te_set | te_clr;
    te_d   = te_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      he_q <= 1'b0;
      te_q <= 1'b0;
    end else begin
      if (he_ce) he_q <= he_d;
      if (te_ce) te_q <= te_d;
    end
  end

  assign irq = ie & ((he_q & he_en) | te_q);

  // R4
  half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_evt && he_en) |=> he_q);

  // R4
  he_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(he_q) |-> $past(half_evt && he_en));

  // R5
  te_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_q) |-> $past(tc_evt));

  // R8
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !stat_wdata[1] && !tc_evt) |=> !te_q);

endmodule

// File: rtl/rdma_chan.sv
module rdma_chan
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              nmi,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              irq
);

  localparam int STEP_B = DATA_W / 8;

  logic [1:0]        rst_pipe;
  logic              rst_s;
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] dstb_q, src_q, dst_q;
  logic [CNT_W-1:0]  cntb_q, cnt_q;
  logic              he_q, te_q, half_evt, tc_evt, run;
  logic              wr_ctrl, wr_stat, wr_src, wr_dst, wr_cnt, wr_dstb, wr_cntb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == REG_CTRL);
    wr_stat = reg_we && (reg_addr == REG_STAT);
    wr_src  = reg_we && (reg_addr == REG_SRC);
    wr_dst  = reg_we && (reg_addr == REG_DST);
    wr_cnt  = reg_we && (reg_addr == REG_CNT);
    wr_dstb = reg_we && (reg_addr == REG_DSTB);
    wr_cntb = reg_we && (reg_addr == REG_CNTB);
  end

  assign run = ctrl_q.en & dma_en;

  rdma_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .wr_ctrl   (wr_ctrl),
    .wr_dstb   (wr_dstb),
    .wr_cntb   (wr_cntb),
    .ctrl_wdata(ctrl_t'(reg_wdata[CTRL_W-1:0])),
    .addr_wdata(reg_wdata[ADDR_W-1:0]),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .nmi       (nmi),
    .ctrl_q    (ctrl_q),
    .dstb_q    (dstb_q),
    .cntb_q    (cntb_q)
  );

  rdma_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STEP_B(STEP_B)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (run),
    .smode     (ctrl_q.smode),
    .dmode     (ctrl_q.dmode),
    .rpt_dst   (ctrl_q.rpt == RPT_DST),
    .dstb      (dstb_q),
    .cntb      (cntb_q),
    .wr_src    (wr_src),
    .wr_dst    (wr_dst),
    .wr_cnt    (wr_cnt),
    .addr_wdata(reg_wdata[ADDR_W-1:0]),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .half_evt  (half_evt),
    .tc_evt    (tc_evt)
  );

  rdma_status u_stat (
    .clk       (clk),
    .rst_n     (rst_s),
    .half_evt  (half_evt),
    .tc_evt    (tc_evt),
    .he_en     (ctrl_q.he_en),
    .ie        (ctrl_q.ie),
    .wr_stat   (wr_stat),
    .stat_wdata(reg_wdata[1:0]),
    .he_q      (he_q),
    .te_q      (te_q),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      REG_STAT: reg_rdata[1:0]        = {te_q, he_q};
      REG_SRC:  reg_rdata[ADDR_W-1:0] = src_q;
      REG_DST:  reg_rdata[ADDR_W-1:0] = dst_q;
      REG_CNT:  reg_rdata[CNT_W-1:0]  = cnt_q;
      REG_DSTB: reg_rdata[ADDR_W-1:0] = dstb_q;
      REG_CNTB: reg_rdata[CNT_W-1:0]  = cntb_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R2
  req_has_count_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && !mem_we) |-> (cnt_q != '0));

endmodule

// File: tb/rdma_chan_tb_top.sv
module rdma_chan_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2, A_DST = 3'd3,
                         A_CNT = 3'd4, A_DSTB = 3'd5, A_CNTB = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n, dma_en, nmi, reg_we, stall;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack, irq;

  logic [31:0] mem  [256];
  logic [31:0] wlog [256];
  int          wr_cnt = 0;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .nmi(nmi),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
  );

  assign mem_ack   = mem_req && !stall;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr[9:2]]  <= mem_wdata;
      wlog[wr_cnt[7:0]]   <= mem_addr;
      wr_cnt              <= wr_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    wr(A_CTRL, 0);
    wr(A_STAT, 0);
    wr(A_SRC, s); wr(A_DST, d); wr(A_CNT, n); wr(A_CNTB, n); wr(A_DSTB, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reg %0d", a), v, 0);
    end
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 mem_req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    int base;
    setup(32'h100, 32'h180, 4);
    base = wr_cnt;
    wr(A_CTRL, 32'h2F);
    wait (wr_cnt == base + 2); @(negedge clk);
    peek(A_STAT, v);
    check("R4 half flag at midpoint", v, 1);
    check("R7 irq on half", {31'b0, irq}, 1);
    wait (wr_cnt == base + 4); @(negedge clk);
    peek(A_STAT, v);
    check("R5 end flag", v, 3);
    peek(A_CNT, v);
    check("R2 count zero", v, 0);
    repeat (20) @(negedge clk);
    check("R5 no more writes", wr_cnt, base + 4);
    check("R5 idle", {31'b0, mem_req}, 0);
    for (int k = 0; k < 4; k++)
      check($sformatf("R2 data word %0d", k), mem[8'h60 + k], 32'hA000_0000 + k);
    rd(A_SRC, v); check("R3 src incremented", v, 32'h110);
    rd(A_DST, v); check("R3 dst incremented", v, 32'h190);
  endtask

  task automatic t_fixed;
    logic [31:0] v;
    int base;
    setup(32'h140, 32'h1C0, 3);
    base = wr_cnt;
    wr(A_CTRL, 32'h21);
    wait (wr_cnt == base + 3); repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++)
      check("R3 fixed src data", mem[8'h70 + k], 32'h5A5A_1234);
    rd(A_SRC, v); check("R3 src fixed", v, 32'h140);
    rd(A_DST, v); check("R3 dst after 3", v, 32'h1CC);
    setup(32'h100, 32'h1F0, 2);
    base = wr_cnt;
    wr(A_CTRL, 32'h09);
    wait (wr_cnt == base + 2); repeat (3) @(negedge clk);
    check("R3 fixed dst last word", mem[8'h7C], 32'hA000_0001);
    rd(A_DST, v); check("R3 dst fixed", v, 32'h1F0);
    rd(A_SRC, v); check("R3 src after 2", v, 32'h108);
  endtask

  task automatic t_stall;
    logic [31:0] v;
    int base;
    setup(32'h100, 32'h1D0, 1);
    stall = 1'b1;
    base = wr_cnt;
    wr(A_CTRL, 32'h29);
    repeat (5) @(negedge clk);
    check("R2 req held", {31'b0, mem_req}, 1);
    check("R2 read phase held", {31'b0, mem_we}, 0);
    check("R2 addr held", mem_addr, 32'h100);
    peek(A_CNT, v); check("R2 count held in stall", v, 1);
    stall = 1'b0;
    wait (wr_cnt == base + 1); repeat (2) @(negedge clk);
    check("R2 stalled word written", mem[8'h74], 32'hA000_0000);
    rd(A_CNT, v); check("R2 count after stall", v, 0);
  endtask

  task automatic t_repeat;
    logic [31:0] v;
    int base, n;
    setup(32'h140, 32'h200, 8);
    base = wr_cnt;
    wr(A_CTRL, 32'h127);
    wait (wr_cnt == base + 4); @(negedge clk);
    peek(A_STAT, v); check("R4 half in repeat", v, 1);
    wr(A_STAT, 32'h2);
    peek(A_STAT, v); check("R8 half cleared by 0", v, 0);
    wait (wr_cnt == base + 8); @(negedge clk);
    peek(A_STAT, v); check("R5 end in repeat", v, 2);
    check("R7 irq on end", {31'b0, irq}, 1);
    peek(A_CNT, v);  check("R6 count reloaded", v, 8);
    peek(A_DST, v);  check("R6 dst reloaded", v, 32'h200);
    wr(A_DSTB, 32'h300);
    wr(A_SRC, 32'h999);
    peek(A_SRC, v);  check("R11 src write ignored while running", v, 32'h140);
    wait (wr_cnt == base + 17); @(negedge clk);
    for (int k = 0; k < 16; k++)
      check($sformatf("R6 ring addr %0d", k), wlog[8'(base + k)], 32'h200 + 4 * (k % 8));
    check("R11 new backup used at next reload", wlog[8'(base + 16)], 32'h300);
    dma_en = 1'b0;
    repeat (6) @(negedge clk);
    n = wr_cnt;
    repeat (20) @(negedge clk);
    check("R9 global stop", wr_cnt, n);
    check("R9 no request", {31'b0, mem_req}, 0);
    peek(A_CTRL, v); check("R9 channel enable kept", v & 1, 1);
    dma_en = 1'b1;
    wait (wr_cnt == n + 1); @(negedge clk);
    check("R9 resumes", wr_cnt, n + 1);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    repeat (6) @(negedge clk);
    n = wr_cnt;
    repeat (20) @(negedge clk);
    check("R10 nmi stops", wr_cnt, n);
    peek(A_CTRL, v); check("R10 enable cleared", v & 1, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    int base;
    setup(32'h100, 32'h1E0, 2);
    rd(A_STAT, v); check("R8 cleared", v, 0);
    check("R7 irq low", {31'b0, irq}, 0);
    base = wr_cnt;
    wr(A_CTRL, 32'h29);
    wait (wr_cnt == base + 2); @(negedge clk);
    peek(A_STAT, v); check("R4 no half without enable", v, 2);
    check("R7 irq masked", {31'b0, irq}, 0);
    wr(A_CTRL, 32'h2);
    check("R7 irq unmasked", {31'b0, irq}, 1);
    wr(A_STAT, 32'h3);
    peek(A_STAT, v); check("R8 write 1 no effect", v, 2);
    wr(A_STAT, 32'h0);
    peek(A_STAT, v); check("R8 write 0 clears", v, 0);
    check("R7 irq drops", {31'b0, irq}, 0);
  endtask

  initial begin
    rst_n = 1'b0; dma_en = 1'b1; nmi = 1'b0; stall = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
    for (int i = 0; i < 4; i++) mem[8'h40 + i] = 32'hA000_0000 + i;
    mem[8'h50] = 32'h5A5A_1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_fixed;
    t_stall;
    t_repeat;
    t_mask;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule